// File: doc/BRIEF.md
# Flash erase command controller

This block models the erase side of a parallel NOR-style flash device at the cycle level. It watches a host bus made of an address bus, a data bus, an active-low chip enable and an active-low write enable. Each low-then-high pulse of write enable, taken while chip enable is low, is one bus write. Six-write command sequences are recognised and start an erase of one sector, one block or the whole array. A sector covers 2K words (`SECT_LOG` = 11). A block covers 32K words, which is 16 sectors (`BLK_SECT_LOG` = 4). The array holds `NUM_BLK` blocks. The array itself is modelled as one "clean" flag per sector, and an erase sets the flags it covers. Each erase takes a configurable number of clock cycles.

A running sector or block erase can be paused with a single-write suspend command and restarted with a single-write resume command. While it is paused, the rest of the array may be accessed and the paused region may not. A chip erase cannot be paused, and it is refused outright when write protect is low. All pins are plain control and status lines. There is no valid/ready stream, so back-pressure does not apply.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset, `erase_st` is 0 (idle), `busy` is 0, `grant` is 1 and every bit of `sect_clean` is 0.
- R2: Every command opens with five unlock writes: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h (address/data). A write that does not match returns the decoder to the first step, and no erase starts from that attempt.
- R3: A sixth write with data 30h starts a sector erase of the sector that holds that address. `erase_st` reads 1 and `busy` is 1 for `SECT_CYC` cycles, counted from the clock after the write's rising strobe. After that, only that sector's bit in `sect_clean` has been set.
- R4: A sixth write with data 50h starts a block erase. It is busy for `BLK_CYC` cycles and then sets the bits of all 16 sectors in the addressed block.
- R5: On the sixth write, the target address is the one present at the falling edge of write enable. The command byte is the one present at the rising edge.
- R6: A sixth write with data 10h at address 555h starts a chip erase (`erase_st` = 2). It lasts `CHIP_CYC` cycles and then sets every bit of `sect_clean`. Data 10h at any other address starts nothing.
- R7: If write protect is low at the sixth write of a chip-erase sequence, the request is dropped: the block stays idle and `sect_clean` does not change.
- R8: While a sector or block erase runs, complete command sequences are discarded, and the erase target never changes.
- R9: A single write of B0h during a sector or block erase moves the block to suspend-pending (`erase_st` = 3, `busy` = 1, `grant` = 0). Exactly `SUSP_LAT` cycles later it reaches suspended (`erase_st` = 4), with `busy` = 0.
- R10: While suspended, `grant` is 0 for addresses inside the paused sector or block and 1 everywhere else. `grant` is 0 whenever `busy` is 1.
- R11: While suspended, a single write of 30h at any address resumes the erase. The erase continues from the cycle count it had when suspend was accepted. Other writes made while suspended are ignored.
- R12: During a chip erase, every write is ignored, suspend included.
- R13: `erase_st` codes are 0 idle, 1 sector/block erase, 2 chip erase, 3 suspend pending and 4 suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Host word address |
| data | input | DW | Host write data (command byte in bits 7:0) |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable strobe, active low |
| wp_n | input | 1 | Write protect, active low |
| erase_st | output | 3 | Controller state code (R13) |
| sect_clean | output | NUM_BLK*16 | Per-sector erased flag |
| grant | output | 1 | Array access to `addr` is allowed |
| busy | output | 1 | An erase or suspend-entry is in progress |

## Verification
A table walks one write at a time through a sector erase that is interrupted by stray unlock writes, a suspend, an ignored command and a resume, and checks the state code after each write. This separates commands that are accepted from commands that are dropped. Directed patterns include a sequence broken at its fifth write, a final write whose address and data change between the two strobe edges, and chip-erase requests at a wrong address or with write protect low. These patterns separate a correct decoder from one that accepts near-misses or latches on the wrong edge. Exact-cycle checks on the sector, block, chip and resumed erases separate a frozen counter during suspend from one that restarts or keeps running. Grant probes on both sides of the sector and block boundaries separate sector-mode from block-mode region matching.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ERASE = 3'd1,
    ST_CHIP  = 3'd2,
    ST_SPEND = 3'd3,
    ST_SUSP  = 3'd4
  } est_e;

  typedef enum logic [1:0] {K_SECT = 2'd0, K_BLK = 2'd1, K_CHIP = 2'd2} kind_e;

  localparam logic [7:0] OP_SECT   = 8'h30;
  localparam logic [7:0] OP_BLK    = 8'h50;
  localparam logic [7:0] OP_CHIP   = 8'h10;
  localparam logic [7:0] OP_SUSP   = 8'hB0;
  localparam logic [7:0] OP_RESUME = 8'h30;
  localparam logic [11:0] UA_A = 12'h555;
  localparam logic [11:0] UA_B = 12'h2AA;

  // Expected {address, data} of unlock write number idx (0..4).
  function automatic logic [19:0] unlock_step(input logic [2:0] idx);
    case (idx)
      3'd0:    return {UA_A, 8'hAA};
      3'd1:    return {UA_B, 8'h55};
      3'd2:    return {UA_A, 8'h80};
      3'd3:    return {UA_A, 8'hAA};
      default: return {UA_B, 8'h55};
    endcase
  endfunction
endpackage

// File: rtl/fes_strobe.sv
module fes_strobe #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          ce_n,
  input  logic          we_n,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          we_q;
  logic [AW-1:0] addr_cap;
  logic          fall, rise;

  assign fall = we_q & ~we_n & ~ce_n;
  assign rise = ~we_q & we_n & ~ce_n;

  // Address taken on the falling strobe, data on the rising strobe (R5).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      addr_cap <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      we_q     <= we_n;
      wr_valid <= rise;
      if (fall) addr_cap <= addr;
      if (rise) begin
        wr_addr <= addr_cap;
        wr_data <= data;
      end
    end
  end
endmodule

// File: rtl/fes_decode.sv
module fes_decode
  import flash_erase_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int SECT_LOG = 11,
  localparam int SI_W    = AW - SECT_LOG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            idle,
  input  logic            wp_n,
  output logic            start,
  output kind_e           start_kind,
  output logic [SI_W-1:0] start_sect
);
  logic [2:0]  step;
  logic [19:0] pat;
  logic        unlock_ok;

  assign pat        = unlock_step(step);
  assign unlock_ok  = (wr_addr == AW'(pat[19:8])) && (wr_data[7:0] == pat[7:0]);
  assign start_sect = wr_addr[AW-1:SECT_LOG];

  // R3 R4 R6 R7: final-write command selection
  always_comb begin
    start      = 1'b0;
    start_kind = K_SECT;
    if (wr_valid && idle && step == 3'd5) begin
      if (wr_data[7:0] == OP_SECT) begin
        start = 1'b1;
      end else if (wr_data[7:0] == OP_BLK) begin
        start      = 1'b1;
        start_kind = K_BLK;
      end else if (wr_data[7:0] == OP_CHIP && wr_addr == AW'(UA_A) && wp_n) begin
        start      = 1'b1;
        start_kind = K_CHIP;
      end
    end
  end

  // R2: any mismatch drops back to step 0; non-idle keeps decoder cleared (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         step <= 3'd0;
    else if (!idle)     step <= 3'd0;
    else if (wr_valid)  step <= (step == 3'd5) ? 3'd0 : (unlock_ok ? step + 3'd1 : 3'd0);
  end
endmodule

// File: rtl/fes_engine.sv
module fes_engine
  import flash_erase_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DW           = 8,
  parameter int SECT_LOG     = 11,
  parameter int BLK_SECT_LOG = 4,
  parameter int NUM_BLK      = 2,
  parameter int SECT_CYC     = 60,
  parameter int BLK_CYC      = 90,
  parameter int CHIP_CYC     = 120,
  parameter int SUSP_LAT     = 6,
  localparam int SI_W        = AW - SECT_LOG,
  localparam int NUM_SECT    = NUM_BLK << BLK_SECT_LOG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  kind_e               start_kind,
  input  logic [SI_W-1:0]     start_sect,
  input  logic                wr_valid,
  input  logic [DW-1:0]       wr_data,
  input  logic [SI_W-1:0]     probe_sect,
  output est_e                st,
  output logic [NUM_SECT-1:0] clean,
  output logic                grant,
  output logic                busy
);
  localparam int MAX_A   = (SECT_CYC > BLK_CYC) ? SECT_CYC : BLK_CYC;
  localparam int MAX_CYC = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int LAT_W   = $clog2(SUSP_LAT + 2);

  logic                kind_blk;
  logic [SI_W-1:0]     tgt_sect;
  logic [CNT_W-1:0]    cnt;
  logic [LAT_W-1:0]    lat;
  logic [NUM_SECT-1:0] hit;
  logic                cmd_susp, cmd_resume;

  assign cmd_susp   = wr_valid && (wr_data[7:0] == OP_SUSP);
  assign cmd_resume = wr_valid && (wr_data[7:0] == OP_RESUME);

  // Sectors covered by the current target (sector or whole block)
  for (genvar i = 0; i < NUM_SECT; i++) begin : g_hit
    localparam logic [SI_W-1:0] IDX = SI_W'(i);
    assign hit[i] = kind_blk ? (IDX[SI_W-1:BLK_SECT_LOG] == tgt_sect[SI_W-1:BLK_SECT_LOG])
                             : (IDX == tgt_sect);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind_blk <= 1'b0;
      tgt_sect <= '0;
      cnt      <= '0;
      lat      <= '0;
      clean    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st       <= (start_kind == K_CHIP) ? ST_CHIP : ST_ERASE;
          kind_blk <= (start_kind == K_BLK);
          tgt_sect <= start_sect;
          cnt      <= (start_kind == K_CHIP) ? CNT_W'(CHIP_CYC - 1) :
                      (start_kind == K_BLK)  ? CNT_W'(BLK_CYC - 1)  : CNT_W'(SECT_CYC - 1);
        end
        ST_ERASE: begin
          if (cnt == '0) begin
            st    <= ST_IDLE;
            clean <= clean | hit;
          end else if (cmd_susp) begin
            st  <= ST_SPEND;
            lat <= LAT_W'(SUSP_LAT - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SPEND: begin
          if (lat == '0) st <= ST_SUSP;
          else           lat <= lat - 1'b1;
        end
        ST_SUSP: if (cmd_resume) st <= ST_ERASE;
        ST_CHIP: begin
          if (cnt == '0) begin
            st    <= ST_IDLE;
            clean <= '1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st == ST_ERASE) || (st == ST_CHIP) || (st == ST_SPEND);

  always_comb begin
    case (st)
      ST_IDLE: grant = 1'b1;
      ST_SUSP: grant = kind_blk ? (probe_sect[SI_W-1:BLK_SECT_LOG] != tgt_sect[SI_W-1:BLK_SECT_LOG])
                                : (probe_sect != tgt_sect);
      default: grant = 1'b0;
    endcase
  end

  // Checker-side age counter for the suspend window
  logic [LAT_W-1:0] pend_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pend_age <= '0;
    else if (st == ST_SPEND) pend_age <= pend_age + 1'b1;
    else                     pend_age <= '0;
  end

  // R9
  susp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_age <= LAT_W'(SUSP_LAT)) else $error("suspend latency exceeded");
  // R12
  chip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHIP && cnt != '0) |=> (st == ST_CHIP)) else $error("chip erase interrupted");
  // R10
  grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !grant) else $error("grant while busy");
  // R8
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(tgt_sect)) else $error("target changed while busy");
  // R3
  clean_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~clean & $past(clean)) == '0)) else $error("clean flag cleared");
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int SECT_LOG     = 11,
  parameter int BLK_SECT_LOG = 4,
  parameter int NUM_BLK      = 2,
  parameter int DW           = 8,
  parameter int SECT_CYC     = 60,
  parameter int BLK_CYC      = 90,
  parameter int CHIP_CYC     = 120,
  parameter int SUSP_LAT     = 6,
  parameter int ADDR_W       = SECT_LOG + BLK_SECT_LOG + $clog2(NUM_BLK)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DW-1:0]                       data,
  input  logic                                ce_n,
  input  logic                                we_n,
  input  logic                                wp_n,
  output logic [2:0]                          erase_st,
  output logic [(NUM_BLK<<BLK_SECT_LOG)-1:0]  sect_clean,
  output logic                                grant,
  output logic                                busy
);
  localparam int SI_W = ADDR_W - SECT_LOG;

  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [DW-1:0]     wr_data;
  logic              start;
  kind_e             start_kind;
  logic [SI_W-1:0]   start_sect;
  est_e              st;

  fes_strobe #(.AW(ADDR_W), .DW(DW)) u_strobe (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .ce_n(ce_n), .we_n(we_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

  fes_decode #(.AW(ADDR_W), .DW(DW), .SECT_LOG(SECT_LOG)) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .idle(st == ST_IDLE), .wp_n(wp_n),
    .start(start), .start_kind(start_kind), .start_sect(start_sect));

  fes_engine #(.AW(ADDR_W), .DW(DW), .SECT_LOG(SECT_LOG), .BLK_SECT_LOG(BLK_SECT_LOG),
               .NUM_BLK(NUM_BLK), .SECT_CYC(SECT_CYC), .BLK_CYC(BLK_CYC),
               .CHIP_CYC(CHIP_CYC), .SUSP_LAT(SUSP_LAT)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_kind(start_kind), .start_sect(start_sect),
    .wr_valid(wr_valid), .wr_data(wr_data), .probe_sect(addr[ADDR_W-1:SECT_LOG]),
    .st(st), .clean(sect_clean), .grant(grant), .busy(busy));

  assign erase_st = st;

  // R7
  wp_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_st == ST_CHIP) |-> $past(wp_n)) else $error("chip erase under write protect");
endmodule

// File: tb/flash_erase_ctrl_tb.sv
module flash_erase_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SECT_CYC = 60;
  localparam int BLK_CYC  = 90;
  localparam int CHIP_CYC = 120;
  localparam int SUSP_LAT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        ce_n = 1'b1, we_n = 1'b1, wp_n = 1'b1;
  logic [2:0]  erase_st;
  logic [31:0] sect_clean;
  logic        grant, busy;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_ctrl #(.SECT_CYC(SECT_CYC), .BLK_CYC(BLK_CYC), .CHIP_CYC(CHIP_CYC),
                     .SUSP_LAT(SUSP_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .ce_n(ce_n), .we_n(we_n),
    .wp_n(wp_n), .erase_st(erase_st), .sect_clean(sect_clean), .grant(grant), .busy(busy));

  // Table: one bus write per row, then wait V_W cycles and expect state V_S (R13 codes)
  localparam int NV = 11;
  localparam int V_A [NV] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA, 'h2800, 'h555, 'h0, 'h555, 'h1234, 'h2AA};
  localparam int V_D [NV] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h30, 'hAA, 'hB0, 'h80, 'h30, 'h55};
  localparam int V_W [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, SUSP_LAT + 2, 1, 1};
  localparam int V_S [NV] = '{0, 0, 0, 0, 0, 1, 1, 3, 4, 1, 1};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr2(input logic [15:0] a0, input logic [15:0] a1,
                         input logic [7:0] d0, input logic [7:0] d1);
    @(negedge clk); addr = a0; data = d0; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = a1; data = d1; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    bus_wr2(a, a, d, d);
  endtask

  task automatic unlock5();
    bus_wr(16'h555, 8'hAA); bus_wr(16'h2AA, 8'h55); bus_wr(16'h555, 8'h80);
    bus_wr(16'h555, 8'hAA); bus_wr(16'h2AA, 8'h55);
  endtask

  task automatic seq6(input logic [15:0] a, input logic [7:0] d);
    unlock5(); bus_wr(a, d);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; wp_n = 1'b1; addr = '0;
    cyc(3); rst_n = 1'b1; cyc(1);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 1000 && erase_st != 3'd0; i++) @(negedge clk);
  endtask

  initial begin
    cyc(100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    // R1 reset state
    check("R1 state", erase_st, 0);
    check("R1 busy", busy, 0);
    check("R1 grant", grant, 1);
    check("R1 clean", sect_clean, 0);

    // Table walk: R2 R3 R9 R11 R13
    for (int i = 0; i < NV; i++) begin
      bus_wr(16'(V_A[i]), 8'(V_D[i]));
      cyc(V_W[i]);
      check($sformatf("R13 table row %0d state", i), erase_st, 64'(V_S[i]));
    end
    wait_done();
    check("R11 table resumed sector done", sect_clean, 32'h0000_0020);

    // R2 broken unlock then final write: nothing starts
    do_reset();
    bus_wr(16'h555, 8'hAA); bus_wr(16'h2AA, 8'h55); bus_wr(16'h555, 8'h80);
    bus_wr(16'h555, 8'hAA); bus_wr(16'h2AA, 8'h56); bus_wr(16'h1800, 8'h30);
    cyc(2);
    check("R2 broken seq state", erase_st, 0);
    check("R2 broken seq clean", sect_clean, 0);

    // R3 sector erase exact duration
    seq6(16'h1800, 8'h30);
    cyc(SECT_CYC);
    check("R3 busy at last cycle", busy, 1);
    cyc(1);
    check("R3 idle after", busy, 0);
    check("R3 only sector 3", sect_clean, 32'h0000_0008);

    // R5 address on falling edge, command on rising edge
    do_reset();
    unlock5();
    bus_wr2(16'h3800, 16'h4800, 8'h50, 8'h30);
    cyc(1);
    check("R5 sector erase started", erase_st, 1);
    wait_done();
    check("R5 falling-edge sector", sect_clean, 32'h0000_0080);

    // R4 block erase exact duration
    do_reset();
    seq6(16'h8000, 8'h50);
    cyc(BLK_CYC);
    check("R4 busy at last cycle", busy, 1);
    cyc(1);
    check("R4 idle after", busy, 0);
    check("R4 block 1 sectors", sect_clean, 32'hFFFF_0000);

    // R8 sequences during sector erase discarded
    do_reset();
    seq6(16'h0800, 8'h30);
    seq6(16'h0555, 8'h10);
    seq6(16'h8000, 8'h50);
    check("R8 still sector erase", erase_st, 1);
    wait_done();
    check("R8 only sector 1", sect_clean, 32'h0000_0002);

    // R9 R10 R11 sector suspend / resume
    do_reset();
    seq6(16'h1000, 8'h30);
    cyc(3);
    bus_wr(16'h4444, 8'hB0);
    cyc(SUSP_LAT);
    check("R9 pending state", erase_st, 3);
    check("R9 pending busy", busy, 1);
    check("R9 pending grant", grant, 0);
    cyc(1);
    check("R9 suspended state", erase_st, 4);
    check("R9 suspended busy", busy, 0);
    addr = 16'h1000; #1; check("R10 sector inside low", grant, 0);
    addr = 16'h17FF; #1; check("R10 sector inside high", grant, 0);
    addr = 16'h1800; #1; check("R10 next sector", grant, 1);
    addr = 16'h0FFF; #1; check("R10 previous sector", grant, 1);
    bus_wr(16'h7777, 8'h30);
    cyc(SECT_CYC - 5);
    check("R11 resumed busy at remaining end", erase_st, 1);
    cyc(1);
    check("R11 resumed done", erase_st, 0);
    check("R11 sector 2 clean", sect_clean, 32'h0000_0004);

    // R10 block suspend region
    do_reset();
    seq6(16'h0100, 8'h50);
    cyc(2);
    bus_wr(16'h0, 8'hB0);
    cyc(SUSP_LAT + 1);
    check("R10 block suspended", erase_st, 4);
    addr = 16'h7FFF; #1; check("R10 block inside", grant, 0);
    addr = 16'h8000; #1; check("R10 other block", grant, 1);
    bus_wr(16'h0, 8'h30);
    wait_done();
    check("R10 block 0 clean", sect_clean, 32'h0000_FFFF);

    // R6 chip erase
    do_reset();
    seq6(16'h0556, 8'h10);
    cyc(2);
    check("R6 wrong address ignored", erase_st, 0);
    seq6(16'h0555, 8'h10);
    cyc(CHIP_CYC);
    check("R6 chip state at last cycle", erase_st, 2);
    cyc(1);
    check("R6 chip done", erase_st, 0);
    check("R6 all clean", sect_clean, 32'hFFFF_FFFF);

    // R12 writes during chip erase ignored
    do_reset();
    seq6(16'h0555, 8'h10);
    cyc(1);
    bus_wr(16'h0, 8'hB0);
    cyc(SUSP_LAT + 2);
    check("R12 suspend ignored", erase_st, 2);
    seq6(16'h2800, 8'h30);
    check("R12 sequence ignored", erase_st, 2);
    wait_done();
    check("R12 chip completes", sect_clean, 32'hFFFF_FFFF);

    // R7 write protect blocks chip erase
    do_reset();
    wp_n = 1'b0;
    seq6(16'h0555, 8'h10);
    cyc(2);
    check("R7 protected state", erase_st, 0);
    check("R7 protected busy", busy, 0);
    check("R7 protected clean", sect_clean, 0);
    wp_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule